// File: doc/BRIEF.md
# Pipelined DES Block Encryptor

This block encrypts 64-bit blocks with the Data Encryption Standard in a fully unrolled pipeline. One load stage applies the initial permutation to the plaintext and the first key selection to the key; sixteen round stages follow, one register stage per round. Each round stage rotates and registers its own copy of the two 28-bit key halves, so every key travels down the pipeline beside its block. A new block with its own key may enter on every clock. After the pipeline fills, one ciphertext leaves on every clock. There is no control state machine: the block is a registered datapath with a valid bit that moves through the same stages.

Callers present a block and a key with `in_valid` high. After a fixed latency of 17 register stages the ciphertext appears with `out_valid` high. The core cannot stall and has no ready signal. Slots entered with `in_valid` low travel through as bubbles.

Top module: `des_pipe_core`

## Requirements
- R1: The output is bit-exact DES encryption. Vector bit 63 is DES bit 1, so hex values read as usual. Three examples: key 133457799BBCDFF1 with plaintext 0123456789ABCDEF gives 85E813540F0AB405; key 0E329232EA6D0D73 with plaintext 8787878787878787 gives 0000000000000000; the all-zero key with the all-zero plaintext gives 8CA64DE9C1B123A7.
- R2: A block whose `in_valid` is sampled high at rising edge n appears on `out_block`, with `out_valid` high, from edge n+16 until edge n+17. That is 17 registers from input to output.
- R3: Blocks accepted on consecutive edges leave on consecutive edges, in the order they entered, one per clock.
- R4: Each block is encrypted with the key that was sampled with it, even when every neighbouring block in flight uses a different key.
- R5: A slot sampled with `in_valid` low gives `out_valid` low exactly 17 stages later. Its data has no effect on any valid block.
- R6: Key bits 0, 8, 16, 24, 32, 40, 48 and 56 are parity bits. Inverting them does not change the ciphertext.
- R7: A synchronous reset (`rst` high at an edge) clears every valid bit. `out_valid` then stays low until a block accepted after reset reaches the output.
- R8: Encrypting the complemented plaintext under the complemented key gives the complemented ciphertext. For example, all-ones key and all-ones plaintext give 7359B2163E4EDC58.
- R9: Under the weak key 0101010101010101, encrypting a block and then encrypting the result returns the original block. This shows that the output permutation undoes the input permutation and that the subkey order is right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears valid bits only |
| in_valid | input | 1 | Marks `in_block`/`in_key` as a block to encrypt this cycle |
| in_block | input | 64 | Plaintext, bit 63 is DES bit 1 |
| in_key | input | 64 | Key including parity bits, bit 63 is DES bit 1 |
| out_valid | output | 1 | High when `out_block` holds a ciphertext |
| out_block | output | 64 | Ciphertext, bit 63 is DES bit 1 |

## Verification
Two functions can fall in the same cycle: a block leaving the last round stage and a new block with a different key entering the load stage. With a 17-deep pipeline, up to seventeen keys are live at once. The bench provokes this in two ways. It streams known-answer, complement and parity-flipped blocks back to back, each with a different key. It also interleaves bubbles that carry junk data and junk keys. Each block is judged only by its own published ciphertext and its exact exit slot. A key mix-up between stages therefore shows up as a wrong ciphertext or a misplaced valid bit.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int BLK_W    = 64;
  localparam int HALF_W   = BLK_W / 2;
  localparam int KEY_W    = 64;
  localparam int CD_W     = 28;
  localparam int SUBKEY_W = 48;
  localparam int N_ROUNDS = 16;
  localparam int N_SBOX   = 8;

  typedef struct packed {
    logic [HALF_W-1:0] l;
    logic [HALF_W-1:0] r;
  } lr_t;

  typedef struct packed {
    logic [CD_W-1:0] c;
    logic [CD_W-1:0] d;
  } cd_t;

  // Round-function output permutation, entry i is the source bit (1 = msb)
  localparam int unsigned P_TAB [32] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

  // Key selection from the 64-bit key into C||D
  localparam int unsigned KSEL1_TAB [56] = '{
    57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
    10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
    14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

  // Subkey selection from C||D
  localparam int unsigned KSEL2_TAB [48] = '{
    14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
    23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Substitution boxes: four rows of sixteen nibbles each, row 0 first
  localparam logic [255:0] SBOX_TBL [N_SBOX] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // Source position (1 = msb) of output position pos (1..64) of the input permutation
  function automatic int unsigned ip_src(input int unsigned pos);
    int unsigned row, col, start;
    row   = (pos - 1) / 8;
    col   = (pos - 1) % 8;
    start = (row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4));
    return start - 8 * col;
  endfunction

  function automatic logic [BLK_W-1:0] init_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int unsigned i = 1; i <= BLK_W; i++) y[BLK_W-i] = x[BLK_W-ip_src(i)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int unsigned i = 1; i <= BLK_W; i++) y[BLK_W-ip_src(i)] = x[BLK_W-i];
    return y;
  endfunction

  // Expansion: six-bit groups overlapping their neighbours by one bit on each side
  function automatic logic [SUBKEY_W-1:0] expand(input logic [HALF_W-1:0] r);
    logic [SUBKEY_W-1:0] y;
    for (int unsigned g = 0; g < 8; g++)
      for (int unsigned p = 0; p < 6; p++)
        y[SUBKEY_W-1-(6*g+p)] = r[HALF_W-1-((4*g+p+31)%32)];
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] round_perm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int unsigned i = 0; i < 32; i++) y[31-i] = x[32-P_TAB[i]];
    return y;
  endfunction

  function automatic cd_t key_select1(input logic [KEY_W-1:0] k);
    logic [55:0] y;
    for (int unsigned i = 0; i < 56; i++) y[55-i] = k[KEY_W-KSEL1_TAB[i]];
    return cd_t'(y);
  endfunction

  function automatic logic [SUBKEY_W-1:0] key_select2(input cd_t cd);
    logic [55:0] v;
    logic [SUBKEY_W-1:0] y;
    v = cd;
    for (int unsigned i = 0; i < 48; i++) y[47-i] = v[56-KSEL2_TAB[i]];
    return y;
  endfunction

  // Left rotation of a key half for round rnd (1..16)
  function automatic int unsigned rot_amount(input int unsigned rnd);
    return (rnd == 1 || rnd == 2 || rnd == 9 || rnd == 16) ? 1 : 2;
  endfunction

  function automatic logic [CD_W-1:0] rotl_half(input logic [CD_W-1:0] x,
                                                 input int unsigned n);
    return (n == 1) ? {x[CD_W-2:0], x[CD_W-1]} : {x[CD_W-3:0], x[CD_W-1:CD_W-2]};
  endfunction

  // Outer bits pick the row, inner four bits pick the column
  function automatic logic [3:0] sbox(input int unsigned box, input logic [5:0] x);
    int unsigned idx;
    idx = {x[5], x[0]} * 16 + x[4:1];
    return SBOX_TBL[box][255-4*idx -: 4];
  endfunction

  function automatic logic [HALF_W-1:0] feistel(input logic [HALF_W-1:0] r,
                                                input logic [SUBKEY_W-1:0] sk);
    logic [SUBKEY_W-1:0] mix;
    logic [HALF_W-1:0]   s;
    mix = expand(r) ^ sk;
    for (int unsigned b = 0; b < N_SBOX; b++)
      s[HALF_W-1-4*b -: 4] = sbox(b, mix[SUBKEY_W-1-6*b -: 6]);
    return round_perm(s);
  endfunction

endpackage

// File: rtl/des_load_stage.sv
module des_load_stage
  import des_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             vld_o,
  output lr_t              lr_o,
  output cd_t              cd_o
);

  logic [BLK_W-1:0] blk_permuted;
  cd_t              cd_selected;

  assign blk_permuted = init_perm(blk_i);
  assign cd_selected  = key_select1(key_i);

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    lr_o <= lr_t'(blk_permuted);
    cd_o <= cd_selected;
  end

  // R7: reset empties the load stage at the next edge
  a_r7_load_cleared: assert property (@(posedge clk) rst |=> !vld_o);

  // R2: the load stage follows in_valid one edge later
  a_r2_load_follows: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);

endmodule

// File: rtl/des_round_stage.sv
module des_round_stage
  import des_pkg::*;
#(
  parameter int unsigned ROUND_IDX = 1
)(
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  input  lr_t  lr_i,
  input  cd_t  cd_i,
  output logic vld_o,
  output lr_t  lr_o,
  output cd_t  cd_o
);

  localparam int unsigned ROT = rot_amount(ROUND_IDX);

  cd_t                 cd_rot;
  logic [SUBKEY_W-1:0] subkey;
  logic [HALF_W-1:0]   f_out;

  assign cd_rot.c = rotl_half(cd_i.c, ROT);
  assign cd_rot.d = rotl_half(cd_i.d, ROT);
  assign subkey   = key_select2(cd_rot);
  assign f_out    = feistel(lr_i.r, subkey);

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    lr_o.l <= lr_i.r;
    lr_o.r <= lr_i.l ^ f_out;
    cd_o   <= cd_rot;
  end

  // R2: a valid block moves on by exactly one stage per edge
  a_r2_valid_step: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);

  // R5: a bubble stays a bubble
  a_r5_bubble_step: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o);

endmodule

// File: rtl/des_pipe_core.sv
module des_pipe_core
  import des_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_block,
  input  logic [KEY_W-1:0] in_key,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_block
);

  localparam int N_STAGES = N_ROUNDS + 1;

  logic vld_s [N_STAGES];
  lr_t  lr_s  [N_STAGES];
  cd_t  cd_s  [N_STAGES];

  des_load_stage u_load (
    .clk   (clk),
    .rst   (rst),
    .vld_i (in_valid),
    .blk_i (in_block),
    .key_i (in_key),
    .vld_o (vld_s[0]),
    .lr_o  (lr_s[0]),
    .cd_o  (cd_s[0])
  );

  for (genvar g = 1; g <= N_ROUNDS; g++) begin : g_round
    des_round_stage #(.ROUND_IDX(g)) u_round (
      .clk   (clk),
      .rst   (rst),
      .vld_i (vld_s[g-1]),
      .lr_i  (lr_s[g-1]),
      .cd_i  (cd_s[g-1]),
      .vld_o (vld_s[g]),
      .lr_o  (lr_s[g]),
      .cd_o  (cd_s[g])
    );
  end

  // Halves swap before the output permutation
  logic [BLK_W-1:0] preout;
  assign preout    = {lr_s[N_ROUNDS].r, lr_s[N_ROUNDS].l};
  assign out_block = final_perm(preout);
  assign out_valid = vld_s[N_ROUNDS];

  // R7: reset leaves no valid block at the output
  a_r7_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  // R4: sixteen rotations total 28 positions, so a block's key halves leave
  // the pipeline equal to the halves its own key loaded sixteen edges earlier
  a_r4_key_travels: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (cd_s[N_ROUNDS] == $past(cd_s[0], 16)));

  // R9: the output permutation undoes the input permutation
  a_r9_perm_inverse: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (final_perm(init_perm(in_block)) == in_block));

endmodule

// File: tb/des_pipe_core_tb.sv
module des_pipe_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_block = '0;
  logic [63:0] in_key = '0;
  logic        out_valid;
  logic [63:0] out_block;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  des_pipe_core u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_block  (in_block),
    .in_key    (in_key),
    .out_valid (out_valid),
    .out_block (out_block)
  );

  localparam int LAT = 17;

  logic        st_v [64];
  logic [63:0] st_p [64];
  logic [63:0] st_k [64];
  logic [63:0] st_e [64];
  logic        ob_v [96];
  logic [63:0] ob_d [96];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive n slots on consecutive negedges and record the outputs
  task automatic run_stream(input int n);
    for (int cyc = 0; cyc < n + 20; cyc++) begin
      @(negedge clk);
      ob_v[cyc] = out_valid;
      ob_d[cyc] = out_block;
      if (cyc < n) begin
        in_valid = st_v[cyc];
        in_block = st_p[cyc];
        in_key   = st_k[cyc];
      end else begin
        in_valid = 1'b0;
        in_block = 64'hDEAD_BEEF_0BAD_F00D ^ 64'(cyc);
        in_key   = ~in_block;
      end
    end
  endtask

  // Valid pattern must match the input pattern delayed by LAT; data as expected
  task automatic verify_stream(input int n, input string req_v, input string req_d);
    for (int cyc = 0; cyc < n + 20; cyc++) begin
      logic ev;
      ev = (cyc >= LAT && cyc - LAT < n) ? st_v[cyc-LAT] : 1'b0;
      chk(req_v, 64'(ob_v[cyc]), 64'(ev));
      if (ev) chk(req_d, ob_d[cyc], st_e[cyc-LAT]);
    end
  endtask

  task automatic put(input int i, input logic v, input logic [63:0] k,
                     input logic [63:0] p, input logic [63:0] e);
    st_v[i] = v; st_k[i] = k; st_p[i] = p; st_e[i] = e;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R7 out_valid after reset", 64'(out_valid), 64'd0);
    end
  endtask

  task automatic t_kat_single;
    put(0, 1, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405);
    run_stream(1); verify_stream(1, "R2 latency", "R1 vector A");
    put(0, 1, 64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000);
    run_stream(1); verify_stream(1, "R2 latency", "R1 vector B");
    put(0, 1, 64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7);
    run_stream(1); verify_stream(1, "R2 latency", "R1 vector C");
  endtask

  task automatic t_back_to_back;
    put(0, 1, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405);
    put(1, 1, 64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000);
    put(2, 1, 64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7);
    put(3, 1, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h7359B2163E4EDC58);
    put(4, 1, ~64'h133457799BBCDFF1, ~64'h0123456789ABCDEF, ~64'h85E813540F0AB405);
    put(5, 1, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405);
    run_stream(6);
    verify_stream(6, "R3 one per clock", "R4 per-block key / R8 complement");
  endtask

  task automatic t_bubbles;
    put(0, 1, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405);
    put(1, 0, 64'hA5A5A5A5A5A5A5A5, 64'h5A5A5A5A5A5A5A5A, 64'h0);
    put(2, 1, 64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000);
    put(3, 0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0);
    put(4, 0, 64'hFFFFFFFFFFFFFFFF, 64'h1111111111111111, 64'h0);
    put(5, 1, 64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7);
    run_stream(6);
    verify_stream(6, "R5 bubble slot", "R5 valid beside bubble");
  endtask

  task automatic t_parity;
    put(0, 1, 64'h133457799BBCDFF1 ^ 64'h0101010101010101, 64'h0123456789ABCDEF,
        64'h85E813540F0AB405);
    put(1, 1, 64'h0101010101010101, 64'h0000000000000000, 64'h8CA64DE9C1B123A7);
    run_stream(2);
    verify_stream(2, "R6 latency", "R6 parity bits ignored");
  endtask

  task automatic t_weak;
    logic [63:0] mid;
    put(0, 1, 64'h0101010101010101, 64'h0123456789ABCDEF, 64'h0);
    run_stream(1);
    chk("R9 first pass valid", 64'(ob_v[LAT]), 64'd1);
    mid = ob_d[LAT];
    put(0, 1, 64'h0101010101010101, mid, 64'h0123456789ABCDEF);
    run_stream(1);
    verify_stream(1, "R9 latency", "R9 weak key involution");
  endtask

  task automatic t_reset_mid;
    for (int cyc = 0; cyc < 12; cyc++) begin
      @(negedge clk);
      in_valid = (cyc < 6);
      in_block = 64'h0123456789ABCDEF + 64'(cyc);
      in_key   = 64'h133457799BBCDFF1;
      rst      = (cyc == 8 || cyc == 9);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      chk("R7 no output after mid-stream reset", 64'(out_valid), 64'd0);
    end
    put(0, 1, 64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405);
    run_stream(1);
    verify_stream(1, "R7 recovery latency", "R7 recovery data");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_kat_single();
    t_back_to_back();
    t_bubbles();
    t_parity();
    t_weak();
    t_reset_mid();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule